// File: doc/BRIEF.md
# Instruction Prefetch Queue with Static Branch Folding

This block sits at the front of an instruction pipeline. It issues word fetches to a simple in-order memory port and keeps up to three returned 32-bit instruction words in a small queue. It hands them to the decode stage over a valid/ready handshake. Each returning word is examined for a branch as it enters the queue. Branches are predicted statically from the direction of their offset, and no history is kept. A predicted-taken branch steers fetch to its target at once. A predicted-not-taken conditional branch never occupies a queue slot. Its condition code and its computed target ride along on the next word that enters the queue, so a later stage can evaluate the condition and recover if the guess was wrong.

When a later stage finds that a prediction was wrong, it pulses the mispredict input with the correct address. The queue empties, every fetch still outstanding is marked stale so its data is dropped, and fetching resumes at the supplied address. Each issued item carries the instruction word, its address, a folded flag, a condition code and an alternate target. The alternate target is the address to use if the prediction made for that item fails.

Top module: `fetch_fold_unit`

## Requirements
- R1: While reset (synchronous, active high) is asserted and on the cycle after it, the queue is empty and no item issues; the first fetch request after reset is to address 0.
- R2: A word is a branch when bits [27:24] equal 4'b1010. Bits [31:28] hold its condition, where 4'hE means unconditional. Bits [23:0] hold a signed word offset, and the target is the branch address + 8 + (offset shifted left by 2, sign-extended).
- R3: A conditional branch with a non-negative offset is predicted not taken. It is removed from the issued stream and takes no queue slot, and fetch continues sequentially.
- R4: The next word queued after a removed branch issues with folded = 1, condition = that branch's condition and alternate target = that branch's computed target.
- R5: A conditional branch with a negative offset is predicted taken and fetch moves to its target. The branch itself issues with folded = 0, and words fetched after it are discarded.
- R6: An unconditional branch redirects fetch to its target and never issues. An unconditional branch to itself therefore stops all issue.
- R7: A word that arrives while a fold is pending is never removed, even if it is a forward conditional branch. It issues carrying the pending fold.
- R8: The queue never holds more than three words. No fetch request is made while queued words plus live outstanding fetches equal three.
- R9: A mispredict pulse empties the queue and drops every outstanding response, and fetch restarts at the supplied address. With memory answering one cycle after each accepted request, the first word from the new address issues in the third cycle after the pulse.
- R10: While an item is valid and not accepted, it stays valid and unchanged until a mispredict.
- R11: An item that is not folded carries condition 4'hE and alternate target equal to its own address + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 32 | Fetch word address |
| rsp_valid | input | 1 | Fetch response valid (in request order) |
| rsp_data | input | 32 | Fetched instruction word |
| mp_valid | input | 1 | Mispredict pulse from a later stage |
| mp_addr | input | 32 | Correct restart address |
| iss_valid | output | 1 | Issued item valid |
| iss_ready | input | 1 | Decode accepts the item |
| iss_instr | output | 32 | Issued instruction word |
| iss_addr | output | 32 | Address of the issued word |
| iss_cond | output | 4 | Condition of a folded branch, else 4'hE |
| iss_folded | output | 1 | A branch was folded into this item |
| iss_alt | output | 32 | Alternate target for recovery |

## Verification
The bound checker watches every cycle for queue occupancy above three, for an item that changes while it is stalled, for an item still visible after a mispredict, for an empty state after reset, and for the field convention of folded versus plain items. Whether each branch kind gets the right prediction, whether folded conditions land on the right successor, whether targets are correct and whether stale words are discarded can only be shown by the bench's program. That program has forward, backward, unconditional and back-to-back branches, and the bench compares the issued stream item by item. The exact three-cycle recovery and the stall once three fetches are held are also measured only by directed scenarios.

// File: rtl/ffu_pkg.sv
package ffu_pkg;
    localparam int XLEN = 32;
    localparam int CCW  = 4;
    localparam logic [3:0]     BR_OPC   = 4'b1010;
    localparam logic [CCW-1:0] COND_ALL = 4'hE;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] alt;
        logic [CCW-1:0]  cond;
        logic            folded;
    } item_t;
endpackage

// File: rtl/ffu_br_decode.sv
module ffu_br_decode
    import ffu_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic [XLEN-1:0] pc,
    output logic            br_hit,
    output logic            br_uncond,
    output logic            br_back,
    output logic [CCW-1:0]  br_cond,
    output logic [XLEN-1:0] br_tgt
);
    always_comb begin
        br_hit    = (word[27:24] == BR_OPC);
        br_cond   = word[31:28];
        br_uncond = (word[31:28] == COND_ALL);
        br_back   = word[23];
        br_tgt    = pc + 32'd8 + {{6{word[23]}}, word[23:0], 2'b00};
    end
endmodule

// File: rtl/ffu_queue.sv
module ffu_queue
    import ffu_pkg::*;
#(
    parameter  int DEPTH = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  item_t         push_data,
    input  logic          pop,
    output item_t         head,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        item_t [DEPTH-1:0] mem;
        logic  [PW-1:0]    rd;
        logic  [PW-1:0]    wr;
        logic  [CW-1:0]    cnt;
    } qstate_t;

    qstate_t q, d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CW'(DEPTH)) || do_pop);
        if (flush) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wr] = push_data;
                d.wr        = nxt(q.wr);
            end
            if (do_pop) d.rd = nxt(q.rd);
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign head  = q.mem[q.rd];
    assign count = q.cnt;
endmodule

// File: rtl/fetch_fold_unit.sv
module fetch_fold_unit
    import ffu_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic            clk,
    input  logic            rst,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [XLEN-1:0] req_addr,
    input  logic            rsp_valid,
    input  logic [XLEN-1:0] rsp_data,
    input  logic            mp_valid,
    input  logic [XLEN-1:0] mp_addr,
    output logic            iss_valid,
    input  logic            iss_ready,
    output logic [XLEN-1:0] iss_instr,
    output logic [XLEN-1:0] iss_addr,
    output logic [CCW-1:0]  iss_cond,
    output logic            iss_folded,
    output logic [XLEN-1:0] iss_alt
);
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int MAXFLY = 2 * DEPTH;
    localparam int IFW    = $clog2(MAXFLY + 1);
    localparam int SW     = IFW + 1;

    typedef struct packed {
        logic [XLEN-1:0] fetch_pc;
        logic [XLEN-1:0] rsp_pc;
        logic [IFW-1:0]  inflight;
        logic [IFW-1:0]  discard;
        logic            pend_v;
        logic [CCW-1:0]  pend_cond;
        logic [XLEN-1:0] pend_tgt;
    } fstate_t;

    fstate_t q, d;

    logic [CW-1:0]   q_count;
    item_t           head, push_data;
    logic            push, fire, keep, redirect, fold_now, drop;
    logic [IFW-1:0]  live;
    logic [SW-1:0]   used;
    logic            br_hit, br_uncond, br_back;
    logic [CCW-1:0]  br_cond;
    logic [XLEN-1:0] br_tgt;

    ffu_br_decode u_dec (
        .word      (rsp_data),
        .pc        (q.rsp_pc),
        .br_hit    (br_hit),
        .br_uncond (br_uncond),
        .br_back   (br_back),
        .br_cond   (br_cond),
        .br_tgt    (br_tgt)
    );

    ffu_queue #(.DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst       (rst),
        .flush     (mp_valid),
        .push      (push),
        .push_data (push_data),
        .pop       (iss_ready),
        .head      (head),
        .count     (q_count)
    );

    always_comb begin
        live      = q.inflight - q.discard;
        used      = SW'(q_count) + SW'(live);
        req_valid = (used < SW'(DEPTH)) && (q.inflight < IFW'(MAXFLY));
        req_addr  = q.fetch_pc;
        fire      = req_valid && req_ready;
        keep      = rsp_valid && (q.discard == '0) && !mp_valid;
        redirect  = br_hit && (br_uncond || br_back);
        fold_now  = br_hit && !br_uncond && !br_back && !q.pend_v;
        drop      = fold_now || (br_hit && br_uncond && !q.pend_v);

        d         = q;
        push      = 1'b0;
        push_data = '0;
        if (fire) d.fetch_pc = q.fetch_pc + 32'd4;
        d.inflight = q.inflight + IFW'(fire) - IFW'(rsp_valid);
        if (rsp_valid && (q.discard != '0)) d.discard = q.discard - 1'b1;

        if (mp_valid) begin
            d.fetch_pc = mp_addr;
            d.rsp_pc   = mp_addr;
            d.discard  = d.inflight;
            d.pend_v   = 1'b0;
        end else if (keep) begin
            d.rsp_pc = q.rsp_pc + 32'd4;
            if (fold_now) begin
                d.pend_v    = 1'b1;
                d.pend_cond = br_cond;
                d.pend_tgt  = br_tgt;
            end else if (!drop) begin
                push             = 1'b1;
                push_data.instr  = rsp_data;
                push_data.addr   = q.rsp_pc;
                push_data.folded = q.pend_v;
                push_data.cond   = q.pend_v ? q.pend_cond : COND_ALL;
                push_data.alt    = q.pend_v ? q.pend_tgt : q.rsp_pc + 32'd4;
                d.pend_v         = 1'b0;
            end
            if (redirect) begin
                d.fetch_pc = br_tgt;
                d.rsp_pc   = br_tgt;
                d.discard  = d.inflight;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign iss_valid  = (q_count != '0);
    assign iss_instr  = head.instr;
    assign iss_addr   = head.addr;
    assign iss_cond   = head.cond;
    assign iss_folded = head.folded;
    assign iss_alt    = head.alt;
endmodule

// File: rtl/ffu_chk.sv
module ffu_chk #(
    parameter int DEPTH = 3,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          mp_valid,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [31:0]   iss_instr,
    input logic [31:0]   iss_addr,
    input logic [3:0]    iss_cond,
    input logic          iss_folded,
    input logic [31:0]   iss_alt,
    input logic [CW-1:0] q_count
);
    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (!iss_valid && q_count == '0));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        q_count <= CW'(DEPTH));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mp_valid |=> !iss_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !mp_valid) |=>
            (iss_valid && $stable(iss_instr) && $stable(iss_addr) && $stable(iss_alt)));

    // R11
    plain_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_folded) |-> (iss_cond == 4'hE && iss_alt == iss_addr + 32'd4));

    // R4
    folded_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_folded) |-> (iss_cond != 4'hE));
endmodule

bind fetch_fold_unit ffu_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mp_valid   (mp_valid),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_instr  (iss_instr),
    .iss_addr   (iss_addr),
    .iss_cond   (iss_cond),
    .iss_folded (iss_folded),
    .iss_alt    (iss_alt),
    .q_count    (q_count)
);

// File: tb/sim_fetch_fold_unit.sv
`timescale 1ns/1ps
module sim_fetch_fold_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid, req_ready, rsp_valid;
    logic [31:0] req_addr, rsp_data, mp_addr;
    logic        mp_valid, iss_valid, iss_ready, iss_folded;
    logic [31:0] iss_instr, iss_addr, iss_alt;
    logic [3:0]  iss_cond;
    int          n_run = 0, n_fail = 0, fire_cnt = 0;

    always #2.5 clk = ~clk;

    fetch_fold_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mp_valid(mp_valid), .mp_addr(mp_addr), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_instr(iss_instr), .iss_addr(iss_addr),
        .iss_cond(iss_cond), .iss_folded(iss_folded), .iss_alt(iss_alt)
    );

    // Program image (R2 encoding): plain words are 0x1000_0000 | address.
    function automatic logic [31:0] prog(input logic [31:0] a);
        case (a)
            32'h04:  return 32'h1A000002; // fwd cond 1, target 0x14
            32'h0C:  return 32'hEA00000B; // uncond, target 0x40
            32'h44:  return 32'h3AFFFFF5; // back cond 3, target 0x20
            32'h24:  return 32'h4A000000; // fwd cond 4, target 0x2C
            32'h28:  return 32'h5A000001; // fwd cond 5, target 0x34
            32'h30:  return 32'hEAFFFFFE; // uncond to itself
            default: return 32'h10000000 | a;
        endcase
    endfunction

    // Memory: always ready, answers one cycle after each accepted request.
    assign req_ready = 1'b1;
    always @(posedge clk) begin
        if (rst) rsp_valid <= 1'b0;
        else     rsp_valid <= req_valid && req_ready;
        rsp_data <= prog(req_addr);
        if (!rst && req_valid && req_ready) fire_cnt <= fire_cnt + 1;
    end

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] instr;
        logic        fold;
        logic [3:0]  cond;
        logic [31:0] alt;
        logic [1:0]  stall;
    } exp_t;

    localparam exp_t EXP [0:6] = '{
        '{32'h00, 32'h10000000, 1'b0, 4'hE, 32'h04, 2'd0},
        '{32'h08, 32'h10000008, 1'b1, 4'h1, 32'h14, 2'd2},
        '{32'h40, 32'h10000040, 1'b0, 4'hE, 32'h44, 2'd1},
        '{32'h44, 32'h3AFFFFF5, 1'b0, 4'hE, 32'h48, 2'd0},
        '{32'h20, 32'h10000020, 1'b0, 4'hE, 32'h24, 2'd3},
        '{32'h28, 32'h5A000001, 1'b1, 4'h4, 32'h2C, 2'd0},
        '{32'h2C, 32'h1000002C, 1'b0, 4'hE, 32'h30, 2'd1}
    };
    localparam string TAGS [0:6] = '{"R1 R11", "R3 R4 R2", "R6 R11", "R5",
                                      "R5 R10", "R7", "R11"};

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all): actual hung expected completion");
        finish_run();
    end

    initial begin
        int snap, seen;
        mp_valid  = 1'b0;
        mp_addr   = '0;
        iss_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!iss_valid, "R1 iss_valid", {63'd0, iss_valid}, 64'd0);
        chk(req_valid && req_addr == 32'h0, "R1 first request",
            {31'd0, req_valid, req_addr}, {31'd0, 1'b1, 32'h0});
        rst = 1'b0;

        // Table walk: issued stream versus expectation.
        for (int i = 0; i < 7; i++) begin
            iss_ready = 1'b0;
            repeat (EXP[i].stall) @(negedge clk);
            iss_ready = 1'b1;
            while (!iss_valid) @(negedge clk);
            chk(iss_addr == EXP[i].addr && iss_instr == EXP[i].instr,
                TAGS[i], {iss_addr, iss_instr}, {EXP[i].addr, EXP[i].instr});
            chk(iss_folded == EXP[i].fold && iss_cond == EXP[i].cond && iss_alt == EXP[i].alt,
                TAGS[i], {27'd0, iss_folded, iss_cond, iss_alt},
                {27'd0, EXP[i].fold, EXP[i].cond, EXP[i].alt});
            @(negedge clk);
        end

        // R6: self-branch at 0x30 never issues.
        seen = 0;
        for (int c = 0; c < 30; c++) begin
            if (iss_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R6 no issue after self-branch", 64'(seen), 64'd0);

        // R8 / R9: redirect with decode stalled; exactly three fetches, then stall.
        iss_ready = 1'b0;
        mp_addr   = 32'h80;
        mp_valid  = 1'b1;
        @(negedge clk);
        mp_valid  = 1'b0;
        snap      = fire_cnt;
        repeat (12) @(negedge clk);
        chk(fire_cnt - snap == 3, "R8 fetches while full", 64'(fire_cnt - snap), 64'd3);
        chk(!req_valid, "R8 request held off", {63'd0, req_valid}, 64'd0);
        chk(iss_valid && iss_addr == 32'h80, "R9 restart address",
            {31'd0, iss_valid, iss_addr}, {31'd0, 1'b1, 32'h80});
        iss_ready = 1'b1;
        @(negedge clk);
        chk(iss_valid && iss_addr == 32'h84, "R10 order after stall",
            {31'd0, iss_valid, iss_addr}, {31'd0, 1'b1, 32'h84});

        // R9: three-cycle recovery while the queue is streaming.
        mp_addr  = 32'h100;
        mp_valid = 1'b1;
        @(negedge clk);
        mp_valid = 1'b0;
        chk(!iss_valid, "R9 flushed, cycle 1", {63'd0, iss_valid}, 64'd0);
        @(negedge clk);
        chk(!iss_valid, "R9 stale dropped, cycle 2", {63'd0, iss_valid}, 64'd0);
        @(negedge clk);
        chk(iss_valid && iss_addr == 32'h100 && iss_instr == 32'h10000100,
            "R9 first word, cycle 3", {iss_valid ? iss_addr : 32'hX, iss_instr},
            {32'h100, 32'h10000100});
        finish_run();
    end
endmodule